// File: doc/BRIEF.md
# Shared System Bus Ownership Arbiter

This block sits on one processing subsystem and stands between the local processor's bus cycles and a system bus that several masters share. The processor starts each cycle as if it were the only master. The arbiter raises a bus request and holds the cycle back, with no sign of contention on the local side, until its active-low priority input grants it the bus. It then turns on the local bus controller and address latch drivers and waits for the shared bus to return its active-low transfer acknowledge. That acknowledge becomes the active-low ready that closes the local cycle.

After each transfer the arbiter decides whether to keep the bus. The choice comes from a 2-bit policy input, which is latched only while the subsystem does not own the bus. The three policies are: let go after every transfer; keep the bus until any other master pulls the shared open-drain request line; or keep it until a master of higher priority takes away the priority input. The bus is released only between transfers. Bus-busy and the drivers drop one clock before the arbiter passes priority down the daisy chain on its priority output.

Top module: `shared_bus_arbiter`

## Requirements
- R1: After a synchronous active-low reset with no cycle pending: busy_n=1, drv_en=0, breq_n=1, cbreq_out_n=1, rdy_n=1, and prio_out_n equals prio_in_n.
- R2: A cycle request (cyc_req=1) from the idle state drives breq_n=0 and cbreq_out_n=0 from the next clock. While prio_in_n=1 the cycle stalls: drv_en=0 and rdy_n=1 for as long as that lasts.
- R3: On the clock edge where a request is pending and prio_in_n=0, ownership begins: drv_en=1 and busy_n=0 after that edge.
- R4: rdy_n is low exactly while the arbiter owns the bus in an active transfer and xack_n=0. A low xack_n has no effect while the bus is not owned.
- R5: Policy 2'b00 (and 2'b11, which behaves the same) releases the bus on the edge that ends every transfer.
- R6: Policy 2'b01 keeps the bus after a transfer. It releases from the parked state when another master pulls the common request line low (the arbiter's own drive of that line is ignored), or when prio_in_n goes high.
- R7: Policy 2'b10 keeps the bus after a transfer and ignores the common request line. It releases only when prio_in_n goes high.
- R8: The bus is never released during a transfer. Losing priority while a transfer is active keeps drv_en=1 until the acknowledge.
- R9: Release takes one gap clock: busy_n=1, drv_en=0 and prio_out_n=1. After that clock the arbiter is idle, and prio_out_n follows prio_in_n again.
- R10: prio_out_n is low only when the arbiter is idle, has no cycle pending, and prio_in_n=0.
- R11: The policy input is latched only while the bus is not owned. A change during a tenure does not alter that tenure's release behaviour.
- R12: A cycle requested while the bus is parked starts on the next edge without arbitration: drv_en stays 1 and cbreq_out_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_req | input | 1 | Local processor has a bus cycle pending; held until ready |
| mode_sel | input | 2 | Release policy: 00/11 each transfer, 01 any requester, 10 higher priority |
| xack_n | input | 1 | Active-low transfer acknowledge from the shared bus |
| rdy_n | output | 1 | Active-low ready to the local processor |
| prio_in_n | input | 1 | Active-low priority grant from upstream or the parallel decoder |
| prio_out_n | output | 1 | Active-low priority passed downstream |
| breq_n | output | 1 | Active-low bus request of this master |
| cbreq_in_n | input | 1 | Observed level of the shared open-drain common request line |
| cbreq_out_n | output | 1 | This master's drive onto the common request line |
| busy_n | output | 1 | Active-low bus busy, low while owned |
| drv_en | output | 1 | Enables the bus controller and address latch drivers |

## Verification
A table of eight vectors runs one full transfer under each policy code, including the duplicate 2'b11. Each vector then applies one of three parked-state events: nothing, another requester on the common line, or loss of priority. The table separates the policies by whether the bus is dropped at the transfer boundary and by which parked event releases it. Directed cases cover a long stall with a stray acknowledge, loss of priority in the middle of a transfer, a policy change during a tenure combined with a second parked transfer, and priority pass-through while idle.

// File: rtl/arb_pkg.sv
// Shared types for the shared-bus arbiter.
// Assumes: two policy bits; code 2'b11 is treated like 2'b00.
package arb_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        POL_EACH    = 2'b00,
        POL_ANY     = 2'b01,
        POL_HIGHER  = 2'b10,
        POL_EACH_B  = 2'b11
    } policy_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_XFER = 3'd2,
        ST_PARK = 3'd3,
        ST_REL  = 3'd4
    } arb_state_t;
endpackage

// File: rtl/arb_policy.sv
// Release policy unit: latches the policy while the bus is not owned
// and turns it into two release decisions, one for the end of a transfer
// and one for the parked state.
// Assumes: other_req already excludes this master's own request drive.
module arb_policy
    import arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              prio_in_n,
    input  logic              other_req,
    output logic              rel_at_end,
    output logic              rel_parked
);
    policy_t mode_q;
    logic    pol_each;
    logic    pol_any;

    // Latch the policy only while the bus is not owned.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= POL_EACH;
        else if (sample)
            mode_q <= policy_t'(mode_sel);
    end

    // Decode the latched policy into release decisions.
    always_comb begin
        pol_each   = (mode_q == POL_EACH) || (mode_q == POL_EACH_B);
        pol_any    = (mode_q == POL_ANY);
        rel_parked = prio_in_n || (pol_any && other_req);
        rel_at_end = pol_each || rel_parked;
    end

    // R11: the policy is frozen throughout an ownership tenure.
    p_mode_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample && !$past(sample)) |-> $stable(mode_q));
endmodule

// File: rtl/arb_fsm.sv
// Ownership state machine: idle, requesting, transfer, parked, and a
// one-clock release gap.
// Assumes: cyc_req stays high until the edge at which ready is given.
module arb_fsm
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_req,
    input  logic       prio_in_n,
    input  logic       xack_n,
    input  logic       rel_at_end,
    input  logic       rel_parked,
    output arb_state_t state
);
    arb_state_t state_nx;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cyc_req) state_nx = ST_WAIT;
            ST_WAIT: if (!prio_in_n) state_nx = ST_XFER;
            ST_XFER: if (!xack_n) state_nx = rel_at_end ? ST_REL : ST_PARK;
            ST_PARK: begin
                if (rel_parked)   state_nx = ST_REL;
                else if (cyc_req) state_nx = ST_XFER;
            end
            ST_REL:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R3: a pending request with priority present gains ownership.
    p_grant_on_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !prio_in_n) |=> (state == ST_XFER));
    // R8: no release while a transfer is unacknowledged.
    p_hold_mid_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && xack_n) |=> (state == ST_XFER));
    // R9: the release gap lasts exactly one clock.
    p_gap_one_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REL) |=> (state == ST_IDLE));
endmodule

// File: rtl/arb_outputs.sv
// Output decode: bus-side and local-side signals from the state,
// plus detection of other requesters on the shared request line.
// Assumes: the common line is a wired-AND of every master's drive.
module arb_outputs
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  arb_state_t state,
    input  logic       cyc_req,
    input  logic       prio_in_n,
    input  logic       xack_n,
    input  logic       cbreq_in_n,
    output logic       breq_n,
    output logic       cbreq_out_n,
    output logic       busy_n,
    output logic       drv_en,
    output logic       rdy_n,
    output logic       prio_out_n,
    output logic       other_req
);
    logic owned;

    // Drive bus-side and local-side signals from the state.
    always_comb begin
        owned       = (state == ST_XFER) || (state == ST_PARK);
        drv_en      = owned;
        busy_n      = !owned;
        breq_n      = !(owned || state == ST_WAIT);
        cbreq_out_n = (state != ST_WAIT);
        rdy_n       = !(state == ST_XFER && !xack_n);
        prio_out_n  = !(state == ST_IDLE && !cyc_req && !prio_in_n);
        other_req   = cbreq_out_n && !cbreq_in_n;
    end

    // R4: ready only reaches the processor while the bus is owned.
    p_ready_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n |-> (drv_en && !busy_n));
    // R10: priority passes only when the bus is neither used nor requested.
    p_pass_when_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !prio_out_n |-> (!drv_en && breq_n && cbreq_out_n));
    // R9: the clock after drivers drop still withholds priority.
    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> prio_out_n);
endmodule

// File: rtl/shared_bus_arbiter.sv
// Per-subsystem arbiter for a multimaster shared bus. It stalls local
// cycles until priority is granted, enables the drivers while it owns
// the bus, and releases according to a latched policy.
// Assumes: synchronous inputs; xack_n is only meaningful while owned.
module shared_bus_arbiter
    import arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_req,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              xack_n,
    output logic              rdy_n,
    input  logic              prio_in_n,
    output logic              prio_out_n,
    output logic              breq_n,
    input  logic              cbreq_in_n,
    output logic              cbreq_out_n,
    output logic              busy_n,
    output logic              drv_en
);
    arb_state_t state;
    logic       rel_at_end;
    logic       rel_parked;
    logic       other_req;
    logic       not_owned;

    // Policy may be sampled only outside a tenure.
    always_comb not_owned = (state == ST_IDLE) || (state == ST_WAIT);

    arb_policy u_policy (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample     (not_owned),
        .mode_sel   (mode_sel),
        .prio_in_n  (prio_in_n),
        .other_req  (other_req),
        .rel_at_end (rel_at_end),
        .rel_parked (rel_parked)
    );

    arb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_req    (cyc_req),
        .prio_in_n  (prio_in_n),
        .xack_n     (xack_n),
        .rel_at_end (rel_at_end),
        .rel_parked (rel_parked),
        .state      (state)
    );

    arb_outputs u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .cyc_req     (cyc_req),
        .prio_in_n   (prio_in_n),
        .xack_n      (xack_n),
        .cbreq_in_n  (cbreq_in_n),
        .breq_n      (breq_n),
        .cbreq_out_n (cbreq_out_n),
        .busy_n      (busy_n),
        .drv_en      (drv_en),
        .rdy_n       (rdy_n),
        .prio_out_n  (prio_out_n),
        .other_req   (other_req)
    );

    // R8: drivers drop only after a completed transfer or from the parked state.
    p_release_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> ($past(!rdy_n) || $past(state == ST_PARK)));
endmodule

// File: tb/test_shared_bus_arbiter.sv
// Self-checking bench: a table of policy vectors, then directed cases.
module test_shared_bus_arbiter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cyc_req;
    logic [1:0] mode_sel;
    logic       xack_n;
    logic       rdy_n;
    logic       prio_in_n;
    logic       prio_out_n;
    logic       breq_n;
    logic       cbreq_in_n;
    logic       cbreq_out_n;
    logic       busy_n;
    logic       drv_en;
    logic       other_n;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Common request line: wired-AND of this master and the others.
    assign cbreq_in_n = cbreq_out_n & other_n;

    shared_bus_arbiter i_shared_bus_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_req     (cyc_req),
        .mode_sel    (mode_sel),
        .xack_n      (xack_n),
        .rdy_n       (rdy_n),
        .prio_in_n   (prio_in_n),
        .prio_out_n  (prio_out_n),
        .breq_n      (breq_n),
        .cbreq_in_n  (cbreq_in_n),
        .cbreq_out_n (cbreq_out_n),
        .busy_n      (busy_n),
        .drv_en      (drv_en)
    );

    // Vector: {mode[1:0], other requester, priority lost, released after transfer, released when parked}
    localparam logic [5:0] VEC [8] = '{
        6'b00_00_10, 6'b11_00_10,
        6'b01_00_00, 6'b01_10_01, 6'b01_01_01,
        6'b10_00_00, 6'b10_10_00, 6'b10_01_01
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    function automatic string mtag(input logic [1:0] m);
        case (m)
            2'b01:   return "R6";
            2'b10:   return "R7";
            default: return "R5";
        endcase
    endfunction

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cyc_req = 1'b0; mode_sel = 2'b00;
        xack_n = 1'b1; prio_in_n = 1'b0; other_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy_n", busy_n, 1'b1);
        chk("R1 drv_en", drv_en, 1'b0);
        chk("R1 breq_n", breq_n, 1'b1);
        chk("R1 cbreq_out_n", cbreq_out_n, 1'b1);
        chk("R1 rdy_n", rdy_n, 1'b1);
        chk("R1 prio_out_n", prio_out_n, 1'b0);

        // Policy table.
        for (int i = 0; i < 8; i++) begin
            logic [5:0] v;
            v = VEC[i];
            mode_sel = v[5:4];
            cyc_req  = 1'b1;
            @(negedge clk);
            chk("R2 request raised", breq_n, 1'b0);
            @(negedge clk);
            chk("R3 owned", drv_en, 1'b1);
            xack_n = 1'b0;
            #1;
            chk("R4 ready on acknowledge", rdy_n, 1'b0);
            @(negedge clk);
            cyc_req = 1'b0;
            xack_n  = 1'b1;
            chk({mtag(v[5:4]), " release at transfer end"}, drv_en, !v[1]);
            if (v[1]) begin
                chk("R9 gap withholds priority", prio_out_n, 1'b1);
                chk("R9 gap busy released", busy_n, 1'b1);
                @(negedge clk);
                chk("R9 priority passed after gap", prio_out_n, 1'b0);
            end else begin
                other_n   = !v[3];
                prio_in_n = v[2];
                @(negedge clk);
                chk({mtag(v[5:4]), " parked release"}, drv_en, !v[0]);
                other_n = 1'b1;
                if (!v[0]) begin
                    prio_in_n = 1'b1;
                    @(negedge clk);
                end
                prio_in_n = 1'b0;
                @(negedge clk);
                chk("R10 idle passes priority", prio_out_n, 1'b0);
            end
        end

        // R2/R4: long stall with a stray acknowledge.
        mode_sel = 2'b00; prio_in_n = 1'b1; cyc_req = 1'b1; xack_n = 1'b0;
        @(negedge clk);
        chk("R2 breq_n while stalled", breq_n, 1'b0);
        chk("R2 cbreq_out_n while stalled", cbreq_out_n, 1'b0);
        chk("R4 stray acknowledge ignored", rdy_n, 1'b1);
        chk("R10 requester withholds priority", prio_out_n, 1'b1);
        repeat (2) @(negedge clk);
        chk("R2 still stalled drv_en", drv_en, 1'b0);
        chk("R2 still stalled rdy_n", rdy_n, 1'b1);
        xack_n = 1'b1; prio_in_n = 1'b0;
        @(negedge clk);
        chk("R3 granted drv_en", drv_en, 1'b1);
        chk("R3 granted busy_n", busy_n, 1'b0);
        xack_n = 1'b0;
        @(negedge clk);
        cyc_req = 1'b0; xack_n = 1'b1;
        @(negedge clk);

        // R8: priority lost mid-transfer.
        cyc_req = 1'b1;
        repeat (2) @(negedge clk);
        prio_in_n = 1'b1;
        @(negedge clk);
        chk("R8 held mid transfer", drv_en, 1'b1);
        @(negedge clk);
        chk("R8 held mid transfer later", drv_en, 1'b1);
        xack_n = 1'b0;
        #1;
        chk("R4 ready after hold", rdy_n, 1'b0);
        @(negedge clk);
        cyc_req = 1'b0; xack_n = 1'b1;
        chk("R8 released at boundary", drv_en, 1'b0);
        prio_in_n = 1'b0;
        @(negedge clk);

        // R11/R12: policy change during tenure, parked transfer.
        mode_sel = 2'b10; cyc_req = 1'b1;
        repeat (2) @(negedge clk);
        xack_n = 1'b0;
        @(negedge clk);
        cyc_req = 1'b0; xack_n = 1'b1; mode_sel = 2'b00;
        @(negedge clk);
        chk("R7 parked", drv_en, 1'b1);
        cyc_req = 1'b1;
        @(negedge clk);
        chk("R12 parked cycle keeps drivers", drv_en, 1'b1);
        chk("R12 no common request", cbreq_out_n, 1'b1);
        xack_n = 1'b0;
        #1;
        chk("R12 parked cycle ready", rdy_n, 1'b0);
        @(negedge clk);
        cyc_req = 1'b0; xack_n = 1'b1;
        chk("R11 latched policy kept", drv_en, 1'b1);
        prio_in_n = 1'b1;
        @(negedge clk);
        prio_in_n = 1'b0;
        @(negedge clk);

        // R10: idle with no priority passes none.
        prio_in_n = 1'b1;
        #1;
        chk("R10 no priority to pass", prio_out_n, 1'b1);
        prio_in_n = 1'b0;
        #1;
        chk("R10 priority passed through", prio_out_n, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule